// File: doc/BRIEF.md
# Message Buffer Control and Flag Logic

This block keeps the control word and status flags of one message buffer in a dual-channel, time-triggered bus controller. Software writes a 16-bit configuration word through a host port. The word sets the transmit mode, which channels the buffer serves, and a masked match on the 6-bit communication cycle count. The host port also reads back the enable and lock status and clears the buffer's interrupt flag by writing a one to it.

The protocol engine drives event inputs: slot status updates, whether the slot was an empty dynamic slot, the transfer direction, buffer enable and lock levels, the current cycle count, and which channel is being served. From these the block produces the interrupt flag and a buffer-active qualifier. The qualifier tells the engine whether this buffer takes part in the slot now being handled.

The configuration word is not reset, so it keeps its value across a reset. The interrupt flag and the enable-edge tracker are reset.

Top module: `mb_ctrl_flags`

## Requirements
- R1: The configuration word packs as follows. Bit 15 is the transmit mode. Bit 14 is channel A and bit 13 is channel B. Bit 12 enables the cycle filter. Bits 11:6 hold the filter mask and bits 5:0 the filter value. An accepted write appears on `cfg_o` one clock after the write strobe.
- R2: `state_tx_o` is high only when the buffer is a transmit buffer (`is_tx_i`=1) and bit 15 is 1 (state mode). A value of 0 in bit 15 selects event mode, and the bit has no effect on receive buffers.
- R3: A configuration write is accepted only while `poc_cfg_i` is high or `enable_i` is low. Any other write leaves `cfg_o` unchanged.
- R4: For a receive buffer, a slot update sets the interrupt flag on the next clock, unless `slot_empty_dyn_i` marks the slot as an empty dynamic slot. In that case the flag is not set.
- R5: For a transmit buffer, every slot update sets the interrupt flag on the next clock, whatever the slot type.
- R6: For a transmit buffer, a change of `enable_i` from 0 to 1 sets the interrupt flag on the next clock.
- R7: A host flag write with data 1 clears the interrupt flag on the next clock. A host flag write with data 0 leaves the flag unchanged.
- R8: `en_sts_o` follows `enable_i` and `lock_sts_o` follows `lock_i` in the same cycle.
- R9: A reset clears the interrupt flag and leaves the configuration word unchanged.
- R10: When bit 12 is 1, a cycle passes the filter if (cycle AND mask) equals (value AND mask). When bit 12 is 0, every cycle passes.
- R11: `active_o` is high only when `enable_i` is 1, the filter passes and the channel being served is assigned to the buffer. `chan_b_i`=0 means channel A and 1 means channel B.
- R12: When a set event and a host clear reach the flag in the same clock, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_wr_i | input | 1 | Configuration write strobe |
| cfg_wdata_i | input | 16 | Configuration write data |
| flag_wr_i | input | 1 | Host write strobe for the interrupt flag |
| flag_wdata_i | input | 1 | Flag write data; 1 clears the flag |
| poc_cfg_i | input | 1 | Protocol controller is in its configuration state |
| is_tx_i | input | 1 | Buffer direction: 1 transmit, 0 receive |
| enable_i | input | 1 | Buffer enabled |
| lock_i | input | 1 | Application holds the buffer lock |
| slot_upd_i | input | 1 | Slot status update event |
| slot_empty_dyn_i | input | 1 | Updated slot was an empty dynamic slot |
| cycle_i | input | 6 | Current communication cycle count |
| chan_b_i | input | 1 | Channel being served: 0 A, 1 B |
| cfg_o | output | 16 | Stored configuration word |
| en_sts_o | output | 1 | Enable status |
| lock_sts_o | output | 1 | Lock status |
| iflag_o | output | 1 | Interrupt flag |
| state_tx_o | output | 1 | Transmit buffer in state mode |
| active_o | output | 1 | Buffer takes part in the current slot |

## Verification
The bench targets several corner cases, and each has a distinct failure signature:
- Empty dynamic slots seen on a receive buffer and on a transmit buffer. A design that ignored direction would either raise a receive flag it should not, or miss a transmit flag.
- The enable rising edge on a transmit buffer. An edge detector that was missing or level-sensitive shows up as an absent flag, or as a flag that comes back after clearing.
- A write-0 to the flag, and a clear that collides with a set in the same clock. These expose a toggle, or the clear winning.
- Filter vectors with zero mask, full mask, partial mask and filtering off, plus channel mismatch and a disabled buffer. These catch inverted masking or wrong channel selection.
- Writes in the run state while enabled, and a reset with a stored word. These show a design that ignores the write gate or resets the configuration.

// File: rtl/mb_pkg.sv
package mb_pkg;
  localparam int CYC_W = 6;

  typedef struct packed {
    logic             tx_state;  // 1: state mode, 0: event mode
    logic             ch_a;
    logic             ch_b;
    logic             filt_en;
    logic [CYC_W-1:0] mask;
    logic [CYC_W-1:0] val;
  } cfg_t;

  localparam int WORD_W = $bits(cfg_t);
endpackage

// File: rtl/mb_cfg_reg.sv
module mb_cfg_reg
  import mb_pkg::*;
(
  input  logic  clk_i,
  input  logic  wr_i,
  input  logic  allow_i,
  input  cfg_t  wdata_i,
  output cfg_t  cfg_o
);
  // Intentionally unreset storage: value survives reset.
  always_ff @(posedge clk_i) begin
    if (wr_i && allow_i) cfg_o <= wdata_i;
  end
endmodule

// File: rtl/mb_cycle_filter.sv
module mb_cycle_filter #(
  parameter int W = 6
) (
  input  logic         en_i,
  input  logic [W-1:0] cycle_i,
  input  logic [W-1:0] mask_i,
  input  logic [W-1:0] val_i,
  output logic         pass_o
);
  logic [W-1:0] bit_ok;

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign bit_ok[i] = ~mask_i[i] | (cycle_i[i] ~^ val_i[i]);
  end

  assign pass_o = ~en_i | (&bit_ok);
endmodule

// File: rtl/mb_irq_flag.sv
module mb_irq_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic is_tx_i,
  input  logic enable_i,
  input  logic slot_upd_i,
  input  logic slot_empty_dyn_i,
  input  logic clr_i,
  output logic flag_o
);
  logic en_q;
  logic set_upd, set_en, set_any;

  assign set_upd = slot_upd_i & (is_tx_i | ~slot_empty_dyn_i);
  assign set_en  = is_tx_i & enable_i & ~en_q;
  assign set_any = set_upd | set_en;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= 1'b0;
      flag_o <= 1'b0;
    end else begin
      en_q   <= enable_i;
      flag_o <= set_any | (flag_o & ~clr_i);  // set beats clear
    end
  end
endmodule

// File: rtl/mb_ctrl_flags.sv
module mb_ctrl_flags
  import mb_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_wr_i,
  input  logic [WORD_W-1:0] cfg_wdata_i,
  input  logic              flag_wr_i,
  input  logic              flag_wdata_i,
  input  logic              poc_cfg_i,
  input  logic              is_tx_i,
  input  logic              enable_i,
  input  logic              lock_i,
  input  logic              slot_upd_i,
  input  logic              slot_empty_dyn_i,
  input  logic [CYC_W-1:0]  cycle_i,
  input  logic              chan_b_i,
  output logic [WORD_W-1:0] cfg_o,
  output logic              en_sts_o,
  output logic              lock_sts_o,
  output logic              iflag_o,
  output logic              state_tx_o,
  output logic              active_o
);
  cfg_t cfg_q;
  logic filt_pass;
  logic chan_hit;

  mb_cfg_reg u_cfg (
    .clk_i   (clk_i),
    .wr_i    (cfg_wr_i),
    .allow_i (poc_cfg_i | ~enable_i),
    .wdata_i (cfg_t'(cfg_wdata_i)),
    .cfg_o   (cfg_q)
  );

  mb_cycle_filter #(.W(CYC_W)) u_filt (
    .en_i    (cfg_q.filt_en),
    .cycle_i (cycle_i),
    .mask_i  (cfg_q.mask),
    .val_i   (cfg_q.val),
    .pass_o  (filt_pass)
  );

  mb_irq_flag u_flag (
    .clk_i            (clk_i),
    .rst_ni           (rst_ni),
    .is_tx_i          (is_tx_i),
    .enable_i         (enable_i),
    .slot_upd_i       (slot_upd_i),
    .slot_empty_dyn_i (slot_empty_dyn_i),
    .clr_i            (flag_wr_i & flag_wdata_i),
    .flag_o           (iflag_o)
  );

  assign chan_hit   = chan_b_i ? cfg_q.ch_b : cfg_q.ch_a;
  assign cfg_o      = cfg_q;
  assign en_sts_o   = enable_i;
  assign lock_sts_o = lock_i;
  assign state_tx_o = is_tx_i & cfg_q.tx_state;
  assign active_o   = enable_i & filt_pass & chan_hit;
endmodule

// File: rtl/mb_ctrl_flags_chk.sv
module mb_ctrl_flags_chk
  import mb_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cfg_wr_i,
  input logic [WORD_W-1:0] cfg_wdata_i,
  input logic              flag_wr_i,
  input logic              flag_wdata_i,
  input logic              poc_cfg_i,
  input logic              is_tx_i,
  input logic              enable_i,
  input logic              slot_upd_i,
  input logic              slot_empty_dyn_i,
  input logic [WORD_W-1:0] cfg_o,
  input logic              iflag_o,
  input logic              active_o
);
  AST_CFG_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_wr_i && poc_cfg_i |=> cfg_o == $past(cfg_wdata_i)); // R1
  AST_CFG_LOCKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_wr_i && !poc_cfg_i && enable_i |=> $stable(cfg_o)); // R3
  AST_RX_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slot_upd_i && !is_tx_i && !slot_empty_dyn_i |=> iflag_o); // R4
  AST_RX_EMPTY_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !iflag_o && slot_upd_i && !is_tx_i && slot_empty_dyn_i |=> !iflag_o); // R4
  AST_TX_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slot_upd_i && is_tx_i |=> iflag_o); // R5
  AST_TX_ENABLE_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_tx_i && $rose(enable_i) |=> iflag_o); // R6
  AST_FLAG_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_wr_i && flag_wdata_i && !slot_upd_i && !(is_tx_i && enable_i) |=> !iflag_o); // R7
  AST_FLAG_W0_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    iflag_o && flag_wr_i && !flag_wdata_i |=> iflag_o); // R7
  AST_SET_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_wr_i && flag_wdata_i && slot_upd_i && is_tx_i |=> iflag_o); // R12
  AST_ACTIVE_ENABLED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_o |-> enable_i); // R11
endmodule

bind mb_ctrl_flags mb_ctrl_flags_chk u_chk (.*);

// File: tb/tb_mb_ctrl_flags.sv
`timescale 1ns/1ps
module tb_mb_ctrl_flags;
  import mb_pkg::*;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              cfg_wr = 0, flag_wr = 0, flag_wdata = 0, poc_cfg = 0;
  logic [WORD_W-1:0] cfg_wdata = '0;
  logic              is_tx = 0, enable = 0, lock = 0, slot_upd = 0, empty_dyn = 0, chan_b = 0;
  logic [CYC_W-1:0]  cycle = '0;
  logic [WORD_W-1:0] cfg_o;
  logic              en_sts, lock_sts, iflag, state_tx, active;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  mb_ctrl_flags dut (
    .clk_i(clk), .rst_ni(rst_n), .cfg_wr_i(cfg_wr), .cfg_wdata_i(cfg_wdata),
    .flag_wr_i(flag_wr), .flag_wdata_i(flag_wdata), .poc_cfg_i(poc_cfg),
    .is_tx_i(is_tx), .enable_i(enable), .lock_i(lock), .slot_upd_i(slot_upd),
    .slot_empty_dyn_i(empty_dyn), .cycle_i(cycle), .chan_b_i(chan_b),
    .cfg_o(cfg_o), .en_sts_o(en_sts), .lock_sts_o(lock_sts), .iflag_o(iflag),
    .state_tx_o(state_tx), .active_o(active)
  );

  task automatic chk(input string req, input logic [WORD_W-1:0] act, input logic [WORD_W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic write_cfg(input logic [WORD_W-1:0] w);
    @(negedge clk); cfg_wr = 1; cfg_wdata = w;
    tick(); cfg_wr = 0;
  endtask

  task automatic clear_flag();
    @(negedge clk); flag_wr = 1; flag_wdata = 1;
    tick(); flag_wr = 0; flag_wdata = 0;
  endtask

  // {cfg, enable, cycle, chan_b, expected active}  (R10, R11)
  typedef struct packed {
    logic [15:0] cfg; logic en; logic [5:0] cyc; logic chb; logic exp;
  } vec_t;
  localparam int NV = 9;
  localparam vec_t VEC [NV] = '{
    '{16'h6000, 1'b1, 6'd5,  1'b0, 1'b1},  // both channels, no filter
    '{16'h4000, 1'b1, 6'd5,  1'b1, 1'b0},  // A only, serving B
    '{16'h2000, 1'b1, 6'd5,  1'b1, 1'b1},  // B only, serving B
    '{16'h50C1, 1'b1, 6'd5,  1'b0, 1'b1},  // mask 3 val 1, cyc 5 match
    '{16'h50C1, 1'b1, 6'd6,  1'b0, 1'b0},  // mask 3 val 1, cyc 6 miss
    '{16'h502A, 1'b1, 6'd17, 1'b0, 1'b1},  // zero mask passes all
    '{16'h5FEA, 1'b1, 6'd42, 1'b0, 1'b1},  // full mask exact
    '{16'h5FEA, 1'b1, 6'd43, 1'b0, 1'b0},  // full mask off by one
    '{16'h6000, 1'b0, 6'd5,  1'b0, 1'b0}   // disabled
  };

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    tick();
    chk("R9 reset flag", iflag, 0);

    // R10 R11 vector walk
    poc_cfg = 1;
    for (int i = 0; i < NV; i++) begin
      write_cfg(VEC[i].cfg);
      enable = VEC[i].en; cycle = VEC[i].cyc; chan_b = VEC[i].chb;
      #1 chk($sformatf("R11 vec %0d", i), active, VEC[i].exp);
    end
    enable = 0;

    // R1 layout and readback
    write_cfg(16'hA5C3);
    chk("R1 readback", cfg_o, 16'hA5C3);

    // R2 mode bit
    write_cfg(16'h8000);
    is_tx = 1; #1 chk("R2 tx state", state_tx, 1);
    is_tx = 0; #1 chk("R2 rx ignores mode", state_tx, 0);

    // R3 write gating
    poc_cfg = 0; enable = 1; tick();
    write_cfg(16'h1234);
    chk("R3 run+enabled ignored", cfg_o, 16'h8000);
    enable = 0;
    write_cfg(16'h1234);
    chk("R3 disabled accepted", cfg_o, 16'h1234);

    // R8 status
    enable = 1; lock = 1; #1
    chk("R8 enable sts", en_sts, 1);
    chk("R8 lock sts", lock_sts, 1);
    lock = 0; #1 chk("R8 lock clr", lock_sts, 0);
    tick();

    // R4 receive flag
    is_tx = 0; clear_flag();
    @(negedge clk); slot_upd = 1; empty_dyn = 1; tick(); slot_upd = 0; empty_dyn = 0;
    chk("R4 rx empty dyn no set", iflag, 0);
    @(negedge clk); slot_upd = 1; tick(); slot_upd = 0;
    chk("R4 rx set", iflag, 1);

    // R7 write 0 / write 1
    @(negedge clk); flag_wr = 1; flag_wdata = 0; tick(); flag_wr = 0;
    chk("R7 write0 keeps", iflag, 1);
    clear_flag();
    chk("R7 write1 clears", iflag, 0);

    // R5 transmit update on empty dyn slot
    is_tx = 1; tick();
    @(negedge clk); slot_upd = 1; empty_dyn = 1; tick(); slot_upd = 0; empty_dyn = 0;
    chk("R5 tx set", iflag, 1);

    // R6 enable rising edge
    @(negedge clk); enable = 0; tick();
    clear_flag();
    chk("R6 pre clear", iflag, 0);
    @(negedge clk); enable = 1; tick();
    chk("R6 enable edge set", iflag, 1);
    clear_flag();
    chk("R6 level does not reset", iflag, 0);

    // R12 set beats clear
    @(negedge clk); slot_upd = 1; flag_wr = 1; flag_wdata = 1; tick();
    slot_upd = 0; flag_wr = 0; flag_wdata = 0;
    chk("R12 set wins", iflag, 1);

    // R9 config survives reset
    enable = 0; is_tx = 0; poc_cfg = 1;
    write_cfg(16'h3C3C);
    @(negedge clk); rst_n = 0; tick(); tick();
    chk("R9 cfg kept in reset", cfg_o, 16'h3C3C);
    chk("R9 flag cleared", iflag, 0);
    @(negedge clk); rst_n = 1; tick();
    chk("R9 cfg kept after reset", cfg_o, 16'h3C3C);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule